// File: doc/BRIEF.md
# Edge-Capture Output Frequency Regulator

This block closes the frequency loop of a multilevel inverter. A squared-up copy of the output current enters on `sense_in`. The block resynchronises this signal to the clock and timestamps each rising edge with a free-running counter. The difference between two successive timestamps is the measured output period, in clock counts.

Each measurement is compared with a target period. One static pin picks the target: the count for a 50 Hz output, or the count for an 80 Hz output. A proportional-integral step then computes a fresh PWM carrier period. The downstream PWM generator uses that one value both as its carrier period and as the interval between its duty-cycle update interrupts, so the two can never drift apart.

The new period leaves the block on a valid/ready stream. A result stays on the port until the consumer takes it. If the sense signal stops toggling for longer than a timeout, a stale flag rises and the last period stays in force.

Top module: `edge_freq_regulator`

## Requirements
- R1: While reset is asserted and right after it, `per_valid` is 0, `stale` is 0 and `per_value` equals the parameter `INT_INIT`.
- R2: A measurement equals the number of clock cycles between two successive rising edges of `sense_in`. The first rising edge after reset, or after the stale flag rises, only arms the capture and yields no result.
- R3: The target period is `TGT_LO` counts (the 50 Hz setting) when `fsel_in` is 0, and `TGT_HI` counts (the 80 Hz setting) when `fsel_in` is 1.
- R4: On each accepted measurement `m` with target `t`, the error is `e = t - m`. The integrator becomes `I' = clamp(I + (e >>> KI_SH))`, where the shift is arithmetic and rounds toward minus infinity.
- R5: The output period is `clamp(I' + (e >>> KP_SH), PER_MIN, PER_MAX)`. This single value serves as both the carrier period and the update-interrupt interval.
- R6: The integrator is always held within `[INT_MIN, INT_MAX]`.
- R7: Each measurement accepted by the regulator yields exactly one `per_valid` transfer. No transfer occurs without a measurement.
- R8: While `per_valid` is 1 and `per_ready` is 0, `per_value` and `per_valid` hold steady. Measurements that complete during such a stall are discarded and do not change the integrator.
- R9: If no rising edge arrives for `TIMEOUT` cycles, `stale` goes to 1, the capture disarms and `per_value` is held. `stale` returns to 0 on the next completed measurement, which is the second edge after the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also drives the timestamp counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_in | input | 1 | Squared-up output current, asynchronous |
| fsel_in | input | 1 | Target select: 0 = low frequency, 1 = high frequency |
| per_valid | output | 1 | New carrier period available |
| per_ready | input | 1 | Consumer accepts the period |
| per_value | output | PER_W | Carrier period and update interval, in counts |
| stale | output | 1 | No edge seen within the timeout |

## Verification
The assertions take several things for granted. `TIMEOUT` is below the range of the timestamp counter, so the modular difference of two stamps is the true period. The clamp limits are ordered and `PER_MAX` fits in `PER_W` bits. They also assume that `fsel_in` does not change within a few cycles before a rising edge whose measurement uses it.

The stimulus respects all of this. Edge spacing runs from 300 to 3000 cycles, far below the 4000-cycle timeout, except for the one gap that is meant to trip the stale flag. The select pin changes one cycle before a rise and then stays put for the whole period. `per_ready` only changes just after a rising clock edge, and well away from any measurement.

// File: rtl/freqreg_pkg.sv
package freqreg_pkg;

  typedef logic signed [31:0] acc_t;

  function automatic acc_t sat(input acc_t v, input acc_t lo, input acc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/freqreg_sync.sv
module freqreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/freqreg_capture.sv
module freqreg_capture #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_s,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_period,
  output logic             stale
);
  localparam int IDLE_W = $clog2(TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT);
  localparam logic [IDLE_W-1:0] TO_M1    = IDLE_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0]  TO_CNT   = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0]  cnt_q, ts_q, meas_q;
  logic [IDLE_W-1:0] idle_q;
  logic              sig_d_q, armed_q, stale_q, mv_q;
  logic              rise;

  assign rise = sig_s & ~sig_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ts_q    <= '0;
      meas_q  <= '0;
      idle_q  <= '0;
      sig_d_q <= 1'b0;
      armed_q <= 1'b0;
      stale_q <= 1'b0;
      mv_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      sig_d_q <= sig_s;
      mv_q    <= 1'b0;
      if (rise) begin
        idle_q  <= '0;
        ts_q    <= cnt_q;
        armed_q <= 1'b1;
        if (armed_q) begin
          mv_q    <= 1'b1;
          meas_q  <= cnt_q - ts_q;
          stale_q <= 1'b0;
        end
      end else begin
        if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
        if (idle_q == TO_M1) begin
          stale_q <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign meas_valid  = mv_q;
  assign meas_period = meas_q;
  assign stale       = stale_q;

  AST_MEAS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mv_q |-> (meas_q != '0 && meas_q <= TO_CNT)); // R2
  AST_STALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> !mv_q); // R9
  AST_STALE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_q) |-> !armed_q); // R9
endmodule

// File: rtl/freqreg_pi.sv
module freqreg_pi
  import freqreg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PER_W    = 12,
  parameter int TGT_LO   = 1000,
  parameter int TGT_HI   = 625,
  parameter int KP_SH    = 1,
  parameter int KI_SH    = 3,
  parameter int INT_INIT = 1954,
  parameter int INT_MIN  = 500,
  parameter int INT_MAX  = 4000,
  parameter int PER_MIN  = 400,
  parameter int PER_MAX  = 4095
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_period,
  input  logic             sel_hi,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PER_W-1:0] out_period
);
  localparam logic [PER_W-1:0] RST_PER = PER_W'(INT_INIT);
  localparam logic [PER_W-1:0] PMIN_V  = PER_W'(PER_MIN);
  localparam logic [PER_W-1:0] PMAX_V  = PER_W'(PER_MAX);

  acc_t integ_q, target, err, integ_nx, per_nx, meas_s;
  logic [PER_W-1:0] per_q;
  logic             vld_q, take;

  always_comb begin
    meas_s   = $signed({{(32-CNT_W){1'b0}}, meas_period});
    target   = sel_hi ? acc_t'(TGT_HI) : acc_t'(TGT_LO);
    err      = target - meas_s;
    integ_nx = sat(integ_q + (err >>> KI_SH), acc_t'(INT_MIN), acc_t'(INT_MAX));
    per_nx   = sat(integ_nx + (err >>> KP_SH), acc_t'(PER_MIN), acc_t'(PER_MAX));
  end

  assign take = meas_valid && (!vld_q || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= acc_t'(INT_INIT);
      per_q   <= RST_PER;
      vld_q   <= 1'b0;
    end else if (take) begin
      integ_q <= integ_nx;
      per_q   <= per_nx[PER_W-1:0];
      vld_q   <= 1'b1;
    end else if (out_ready) begin
      vld_q   <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_period = per_q;

  AST_PER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (per_q >= PMIN_V && per_q <= PMAX_V)); // R5
  AST_INT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q >= acc_t'(INT_MIN) && integ_q <= acc_t'(INT_MAX))); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(per_q))); // R8
  AST_STALL_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> $stable(integ_q)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> ($stable(per_q) && $stable(integ_q))); // R7
  AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && !meas_valid) |=> !vld_q); // R7
endmodule

// File: rtl/edge_freq_regulator.sv
module edge_freq_regulator #(
  parameter int SYNC_ST  = 2,
  parameter int CNT_W    = 16,
  parameter int PER_W    = 12,
  parameter int TIMEOUT  = 4000,
  parameter int TGT_LO   = 1000,
  parameter int TGT_HI   = 625,
  parameter int KP_SH    = 1,
  parameter int KI_SH    = 3,
  parameter int INT_INIT = 1954,
  parameter int INT_MIN  = 500,
  parameter int INT_MAX  = 4000,
  parameter int PER_MIN  = 400,
  parameter int PER_MAX  = 4095
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_in,
  input  logic             fsel_in,
  output logic             per_valid,
  input  logic             per_ready,
  output logic [PER_W-1:0] per_value,
  output logic             stale
);
  logic             sense_s, fsel_s, mv;
  logic [CNT_W-1:0] mp;

  freqreg_sync #(.STAGES(SYNC_ST)) u_sync_sense (
    .clk(clk), .rst_n(rst_n), .d_in(sense_in), .q_out(sense_s));

  freqreg_sync #(.STAGES(SYNC_ST)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d_in(fsel_in), .q_out(fsel_s));

  freqreg_capture #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cap (
    .clk(clk), .rst_n(rst_n), .sig_s(sense_s),
    .meas_valid(mv), .meas_period(mp), .stale(stale));

  freqreg_pi #(
    .CNT_W(CNT_W), .PER_W(PER_W), .TGT_LO(TGT_LO), .TGT_HI(TGT_HI),
    .KP_SH(KP_SH), .KI_SH(KI_SH), .INT_INIT(INT_INIT),
    .INT_MIN(INT_MIN), .INT_MAX(INT_MAX),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .meas_valid(mv), .meas_period(mp),
    .sel_hi(fsel_s), .out_valid(per_valid), .out_ready(per_ready),
    .out_period(per_value));

  AST_STALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && !mv) |=> $stable(per_value)); // R9
endmodule

// File: tb/edge_freq_regulator_tb.sv
module edge_freq_regulator_tb;
  localparam int CLK_NS   = 10;
  localparam int TIMEOUT  = 4000;
  localparam int TGT_LO   = 1000;
  localparam int TGT_HI   = 625;
  localparam int KP_SH    = 1;
  localparam int KI_SH    = 3;
  localparam int INT_INIT = 1954;
  localparam int INT_MIN  = 500;
  localparam int INT_MAX  = 4000;
  localparam int PER_MIN  = 400;
  localparam int PER_MAX  = 4095;

  logic clk = 0, rst_n = 0, sense_in = 0, fsel_in = 0, per_ready = 1;
  logic per_valid, stale;
  logic [11:0] per_value;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];
  int m_integ = INT_INIT, m_last = 0, m_out = INT_INIT;
  bit m_armed = 0, m_pending = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_freq_regulator #(
    .SYNC_ST(2), .CNT_W(16), .PER_W(12), .TIMEOUT(TIMEOUT),
    .TGT_LO(TGT_LO), .TGT_HI(TGT_HI), .KP_SH(KP_SH), .KI_SH(KI_SH),
    .INT_INIT(INT_INIT), .INT_MIN(INT_MIN), .INT_MAX(INT_MAX),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sense_in(sense_in), .fsel_in(fsel_in),
    .per_valid(per_valid), .per_ready(per_ready), .per_value(per_value),
    .stale(stale));

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of one rising edge: R2 measurement, R3 target, R4/R6 integrator, R5 output
  task automatic model_edge(string tag);
    int now, m, t, e;
    now = cyc;
    if (m_armed && (now - m_last) > TIMEOUT) m_armed = 0;
    if (m_armed && !m_pending) begin
      m = now - m_last;
      t = fsel_in ? TGT_HI : TGT_LO;
      e = t - m;
      m_integ = clampi(m_integ + (e >>> KI_SH), INT_MIN, INT_MAX);
      m_out = clampi(m_integ + (e >>> KP_SH), PER_MIN, PER_MAX);
      exp_q.push_back(m_out);
      tag_q.push_back(tag);
      if (!per_ready) m_pending = 1;
    end
    m_last = now;
    m_armed = 1;
  endtask

  // Driver: one rising edge now, next call rises p cycles later
  task automatic run_period(int p, string tag);
    @(negedge clk);
    sense_in = 1;
    model_edge(tag);
    repeat (p/2) @(negedge clk);
    sense_in = 0;
    repeat (p - p/2 - 1) @(negedge clk);
  endtask

  task automatic set_ready(bit v);
    @(posedge clk);
    #1 per_ready = v;
    if (v) m_pending = 0;
  endtask

  // Monitor: R7 one transfer per accepted measurement
  always @(negedge clk) begin
    if (rst_n && per_valid && per_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected transfer", int'(per_value), -1);
      end else begin
        int e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(int'(per_value) == e, tg, int'(per_value), e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int held;
    repeat (4) @(negedge clk);
    chk(per_valid == 0 && stale == 0, "R1 in reset valid/stale", int'(per_valid), 0);
    chk(int'(per_value) == INT_INIT, "R1 in reset period", int'(per_value), INT_INIT);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(per_valid == 0, "R1 after reset valid", int'(per_valid), 0);
    chk(int'(per_value) == INT_INIT, "R1 after reset period", int'(per_value), INT_INIT);

    fsel_in = 0;
    run_period(1000, "R2 first edge arms");
    chk(per_valid == 0, "R2 no output on arming edge", int'(per_valid), 0);
    run_period(1000, "R3 R4 low target steady");
    run_period(900,  "R4 short period low target");
    run_period(1100, "R4 long period low target");

    fsel_in = 1;
    run_period(625, "R3 high target transition");
    run_period(625, "R3 high target steady");
    run_period(700, "R4 high target slow");

    fsel_in = 0;
    for (int i = 0; i < 25; i++) run_period(300, "R5 R6 upper clamp");
    fsel_in = 1;
    for (int i = 0; i < 12; i++) run_period(3000, "R5 R6 lower clamp");

    run_period(800, "R4 recovery");
    set_ready(0);
    run_period(800, "R8 stalled result");
    held = int'(per_value);
    run_period(800, "R8 discarded edge");
    repeat (5) @(negedge clk);
    chk(per_valid == 1, "R8 valid held in stall", int'(per_valid), 1);
    chk(int'(per_value) == held, "R8 value held in stall", int'(per_value), held);
    set_ready(1);
    run_period(800, "R8 after stall");
    run_period(800, "R8 after stall steady");

    repeat (2 * TIMEOUT + 10) @(negedge clk);
    chk(stale == 1, "R9 stale after gap", int'(stale), 1);
    chk(int'(per_value) == m_out, "R9 period held", int'(per_value), m_out);
    run_period(700, "R9 rearm edge");
    chk(stale == 1, "R9 stale until measurement", int'(stale), 1);
    run_period(700, "R9 first measure after gap");
    repeat (5) @(negedge clk);
    chk(stale == 0, "R9 stale cleared", int'(stale), 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected transfers seen", exp_q.size(), 0);
    finish_run();
  end
endmodule